// File: doc/BRIEF.md
# Three-Slot TDM Serial Port Controller

This block drives a synchronous time-division serial port that carries three 8-bit channels per frame: slot A, then slot B, then slot C. A slot timer running on a 1.536 MHz system clock divides each 125 us frame into 24 bit periods of 8 system clocks. From that timer the block produces a 192 kHz bit clock with selectable polarity and an 8 kHz frame strobe. The strobe is high for the whole of slot A. A one-cycle frame reference pulse re-aligns the timer. Without one, the timer free-runs with the same period.

On transmit, a 24-bit parallel word is captured as the frame begins and shifted out MSB first. On receive, the serial input is sampled at mid-bit, and all three received bytes are presented together once the last bit of slot C has been sampled. A small state machine decides whether the clock, strobe and serial output pins are driven. Pins stay released after reset until a channel connection has been programmed, and they are released again while the port is disabled or powered down. In idle, the strobe is forced low and the bit clock keeps running.

Top module: `tdm_port_ctrl`

## Requirements
- R1: The bit clock lasts 8 system clocks per bit. With `clk_pol`=0, `sclk_o` is low for counts 0-3 of a bit and high for counts 4-7. With `clk_pol`=1, it is the inverse.
- R2: A frame is 24 bits. When not idle, `fs_o` is high exactly during bits 0-7 (slot A) and low during bits 8-23.
- R3: Without a frame reference, the timer free-runs with a frame period of 192 system clocks.
- R4: A `frame_ref` pulse sampled at a clock edge puts the timer at bit 0, count 0 in the next cycle. This applies from any position in the frame.
- R5: After reset, `sclk_oe`, `fs_oe` and `sout_oe` are low. They stay low until `mux_prog` has been seen high at least once. That arming is sticky until reset.
- R6: While `port_en` is low, all three output enables are low. They return when `port_en` is raised again, with no new arming needed.
- R7: While `pdown` is high, all three output enables are low.
- R8: While `idle` is high, `fs_o` is low, the bit clock keeps toggling, and the output enables are unaffected.
- R9: `tx_frame_i` is captured when the timer enters bit 0. Bits [23:16] go to slot A, [15:8] to slot B and [7:0] to slot C. Frame bit b drives `sout_o` = captured bit (23-b) for the whole bit period. Changes to `tx_frame_i` after capture have no effect until the next frame.
- R10: `sin_i` is sampled at count 4 of each bit, using the same bit mapping as R9. `rx_frame_o` updates all 24 bits one clock after the sample of bit 23, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8 per bit period |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_ref | input | 1 | One-cycle line-frame alignment pulse |
| port_en | input | 1 | Port enable |
| mux_prog | input | 1 | Channel connection programmed (arms the pins) |
| idle | input | 1 | Idle mode: frame strobe held low |
| pdown | input | 1 | Power-down: pins released |
| clk_pol | input | 1 | Bit clock polarity select |
| tx_frame_i | input | 24 | Transmit bytes, slot A in the top byte |
| rx_frame_o | output | 24 | Received bytes, slot A in the top byte |
| sin_i | input | 1 | Serial data in |
| sout_o | output | 1 | Serial data out |
| sout_oe | output | 1 | Serial out drive enable |
| sclk_o | output | 1 | Bit clock |
| sclk_oe | output | 1 | Bit clock drive enable |
| fs_o | output | 1 | Frame strobe |
| fs_oe | output | 1 | Frame strobe drive enable |

## Verification
Control inputs reach the pin enables and the strobe in the same cycle, except `mux_prog`, whose arming is registered and shows one clock later. A frame reference moves the timer one edge after it is sampled, so the bench aligns with a pulse and then indexes every expectation by the number of clocks since that edge. With that index, clock level and strobe are checked on every cycle, serial output is checked at mid-bit, and the received word is checked both on the cycle before its update and on the cycle after. All samples are taken on the falling system clock, away from the edge that updates the design.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

  // Level of the bit clock pin for a given count inside the bit.
  function automatic logic bclk_level(input int unsigned cnt,
                                      input int unsigned clks_per_bit,
                                      input logic        pol);
    return ((cnt >= clks_per_bit / 2) ? 1'b1 : 1'b0) ^ pol;
  endfunction

  // Position in the parallel word of frame bit b (MSB first).
  function automatic int unsigned word_index(input int unsigned b,
                                             input int unsigned frame_bits);
    return frame_bits - 1 - b;
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int CLKS_PER_BIT = 8,
  parameter int FRAME_BITS   = 24,
  localparam int DIV_W = $clog2(CLKS_PER_BIT),
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ref,
  output logic [DIV_W-1:0] div_q,
  output logic [BIT_W-1:0] bit_q,
  output logic             sample_pt,
  output logic             frame_wrap,
  output logic             last_sample
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLKS_PER_BIT / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic bit_end;

  assign bit_end     = (div_q == DIV_LAST);
  assign frame_wrap  = frame_ref | (bit_end & (bit_q == BIT_LAST));
  assign sample_pt   = (div_q == DIV_HALF);
  assign last_sample = sample_pt & (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
    end else if (frame_wrap) begin
      div_q <= '0;
      bit_q <= '0;
    end else if (bit_end) begin
      div_q <= '0;
      bit_q <= bit_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_pin_ctrl.sv
module tdm_pin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic mux_prog,
  input  logic pdown,
  output logic armed,
  output logic active
);
  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (mux_prog) armed <= 1'b1;
  end

  assign active = port_en & armed & ~pdown;
endmodule

// File: rtl/tdm_chan_shifter.sv
module tdm_chan_shifter #(
  parameter int FRAME_BITS = 24,
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_wrap,
  input  logic                  sample_pt,
  input  logic                  last_sample,
  input  logic [BIT_W-1:0]      bit_idx,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  sin,
  output logic                  sout,
  output logic [FRAME_BITS-1:0] rx_word
);
  localparam logic [BIT_W-1:0] TOP = BIT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] tx_shadow;
  logic [FRAME_BITS-2:0] rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n)          tx_shadow <= '0;
    else if (frame_wrap) tx_shadow <= tx_word;
  end

  assign sout = tx_shadow[TOP - bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      rx_word <= '0;
    end else if (sample_pt) begin
      rx_sh <= {rx_sh[FRAME_BITS-3:0], sin};
      if (last_sample) rx_word <= {rx_sh, sin};
    end
  end
endmodule

// File: rtl/tdm_port_ctrl.sv
module tdm_port_ctrl #(
  parameter int CLKS_PER_BIT = 8,
  parameter int SLOT_BITS    = 8,
  parameter int SLOTS        = 3,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int DIV_W      = $clog2(CLKS_PER_BIT),
  localparam int BIT_W      = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_ref,
  input  logic                  port_en,
  input  logic                  mux_prog,
  input  logic                  idle,
  input  logic                  pdown,
  input  logic                  clk_pol,
  input  logic [FRAME_BITS-1:0] tx_frame_i,
  output logic [FRAME_BITS-1:0] rx_frame_o,
  input  logic                  sin_i,
  output logic                  sout_o,
  output logic                  sout_oe,
  output logic                  sclk_o,
  output logic                  sclk_oe,
  output logic                  fs_o,
  output logic                  fs_oe
);
  import tdm_port_pkg::*;

  localparam logic [BIT_W-1:0] FS_END = BIT_W'(SLOT_BITS);

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic             sample_pt;
  logic             frame_wrap;
  logic             last_sample;
  logic             armed;
  logic             active;
  logic             in_first_slot;

  tdm_slot_timer #(.CLKS_PER_BIT(CLKS_PER_BIT), .FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_ref(frame_ref),
    .div_q(div_q), .bit_q(bit_q), .sample_pt(sample_pt),
    .frame_wrap(frame_wrap), .last_sample(last_sample)
  );

  tdm_pin_ctrl u_pins (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .mux_prog(mux_prog),
    .pdown(pdown), .armed(armed), .active(active)
  );

  tdm_chan_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .frame_wrap(frame_wrap), .sample_pt(sample_pt),
    .last_sample(last_sample), .bit_idx(bit_q), .tx_word(tx_frame_i),
    .sin(sin_i), .sout(sout_o), .rx_word(rx_frame_o)
  );

  assign in_first_slot = (bit_q < FS_END);
  assign sclk_o  = bclk_level(32'(div_q), CLKS_PER_BIT, clk_pol);
  assign fs_o    = in_first_slot & ~idle;
  assign sclk_oe = active;
  assign fs_oe   = active;
  assign sout_oe = active;
endmodule

// File: rtl/tdm_port_ctrl_chk.sv
module tdm_port_ctrl_chk #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DIV_W        = 3,
  parameter int BIT_W        = 5,
  parameter int FRAME_BITS   = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_ref,
  input logic                  clk_pol,
  input logic                  idle,
  input logic                  port_en,
  input logic                  pdown,
  input logic [DIV_W-1:0]      div_q,
  input logic [BIT_W-1:0]      bit_q,
  input logic                  frame_wrap,
  input logic                  last_sample,
  input logic                  sclk_o,
  input logic                  fs_o,
  input logic                  sout_o,
  input logic                  sclk_oe,
  input logic                  fs_oe,
  input logic                  sout_oe,
  input logic [FRAME_BITS-1:0] rx_frame_o
);
  localparam logic [DIV_W-1:0] PRE_HALF = DIV_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (div_q == '0 && bit_q == '0)); // R4
  AST_SCLK_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == PRE_HALF && !frame_ref) |=>
      (sclk_o != $past(sclk_o)) || (clk_pol != $past(clk_pol))); // R1
  AST_FS_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_o) |-> (bit_q == '0 || $fell(idle))); // R2
  AST_SOUT_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != DIV_LAST && !frame_ref) |=> $stable(sout_o)); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_sample |=> $stable(rx_frame_o)); // R10
  AST_PDOWN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |-> (!sclk_oe && !fs_oe && !sout_oe)); // R7
  AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe || fs_oe || sout_oe) |-> port_en); // R6
endmodule

bind tdm_port_ctrl tdm_port_ctrl_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT), .DIV_W(DIV_W), .BIT_W(BIT_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ref(frame_ref), .clk_pol(clk_pol), .idle(idle),
  .port_en(port_en), .pdown(pdown), .div_q(div_q), .bit_q(bit_q),
  .frame_wrap(frame_wrap), .last_sample(last_sample), .sclk_o(sclk_o), .fs_o(fs_o),
  .sout_o(sout_o), .sclk_oe(sclk_oe), .fs_oe(fs_oe), .sout_oe(sout_oe),
  .rx_frame_o(rx_frame_o)
);

// File: tb/tdm_port_ctrl_tb.sv
module tdm_port_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_ref = 1'b0;
  logic        port_en = 1'b0;
  logic        mux_prog = 1'b0;
  logic        idle = 1'b0;
  logic        pdown = 1'b0;
  logic        clk_pol = 1'b0;
  logic [23:0] tx_frame_i = '0;
  logic [23:0] rx_frame_o;
  logic        sin_i = 1'b0;
  logic        sout_o, sout_oe, sclk_o, sclk_oe, fs_o, fs_oe;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  tdm_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .frame_ref(frame_ref), .port_en(port_en),
    .mux_prog(mux_prog), .idle(idle), .pdown(pdown), .clk_pol(clk_pol),
    .tx_frame_i(tx_frame_i), .rx_frame_o(rx_frame_o), .sin_i(sin_i),
    .sout_o(sout_o), .sout_oe(sout_oe), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .fs_o(fs_o), .fs_oe(fs_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // Expected clock level: low in the first half of a bit, then inverted by polarity.
  function automatic logic exp_sclk(input int n, input logic pol);
    return (((n % 8) < 4) ? 1'b0 : 1'b1) ^ pol;
  endfunction

  function automatic logic exp_fs(input int n);
    return ((n % 192) / 8) < 8;
  endfunction

  // Leaves the bench at the falling edge of the cycle where the timer sits at bit 0, count 0.
  task automatic align();
    @(negedge clk) frame_ref = 1'b1;
    @(negedge clk) frame_ref = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 sclk_oe after reset", 32'(sclk_oe), 0);
    chk("R5 fs_oe after reset", 32'(fs_oe), 0);
    chk("R5 sout_oe after reset", 32'(sout_oe), 0);
    chk("R10 rx after reset", 32'(rx_frame_o), 0);
  endtask

  task automatic t_arming();
    port_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R5 enabled but unarmed", {29'd0, sclk_oe, fs_oe, sout_oe}, 0);
    mux_prog = 1'b1;
    @(negedge clk) mux_prog = 1'b0;
    chk("R5 armed by mux_prog", {29'd0, sclk_oe, fs_oe, sout_oe}, 32'h7);
    port_en = 1'b0;
    @(negedge clk);
    chk("R6 disabled releases pins", {29'd0, sclk_oe, fs_oe, sout_oe}, 0);
    port_en = 1'b1;
    @(negedge clk);
    chk("R6 re-enable without re-arming", {29'd0, sclk_oe, fs_oe, sout_oe}, 32'h7);
  endtask

  task automatic t_clock_frame(input logic pol);
    clk_pol = pol;
    align();
    for (int n = 0; n < 384; n++) begin
      chk(pol ? "R1 sclk pol1" : "R1 sclk pol0", 32'(sclk_o), 32'(exp_sclk(n, pol)));
      chk("R2 R3 fs free-run", 32'(fs_o), 32'(exp_fs(n)));
      @(negedge clk);
    end
    clk_pol = 1'b0;
  endtask

  task automatic t_relock();
    align();
    repeat (77) @(negedge clk);
    chk("R4 before relock fs low", 32'(fs_o), 0);
    align();
    for (int n = 0; n < 200; n++) begin
      chk("R4 relock sclk", 32'(sclk_o), 32'(exp_sclk(n, 1'b0)));
      chk("R4 relock fs", 32'(fs_o), 32'(exp_fs(n)));
      @(negedge clk);
    end
  endtask

  task automatic t_idle();
    idle = 1'b1;
    align();
    for (int n = 0; n < 192; n++) begin
      chk("R8 idle fs low", 32'(fs_o), 0);
      chk("R8 idle sclk runs", 32'(sclk_o), 32'(exp_sclk(n, 1'b0)));
      chk("R8 idle oe kept", {30'd0, sclk_oe, fs_oe}, 32'h3);
      @(negedge clk);
    end
    idle = 1'b0;
  endtask

  task automatic t_pdown();
    pdown = 1'b1;
    @(negedge clk);
    chk("R7 pdown releases pins", {29'd0, sclk_oe, fs_oe, sout_oe}, 0);
    repeat (5) @(negedge clk);
    chk("R7 pdown still released", {29'd0, sclk_oe, fs_oe, sout_oe}, 0);
    pdown = 1'b0;
    @(negedge clk);
    chk("R7 pdown exit drives", {29'd0, sclk_oe, fs_oe, sout_oe}, 32'h7);
  endtask

  task automatic t_tx(input logic [23:0] word, input logic [23:0] late);
    tx_frame_i = word;
    align();
    for (int n = 0; n < 192; n++) begin
      if (n == 100) tx_frame_i = late;
      if (n % 8 == 4) chk("R9 sout bit", 32'(sout_o), 32'(word[23 - n / 8]));
      @(negedge clk);
    end
    for (int n = 0; n < 64; n++) begin
      if (n % 8 == 4) chk("R9 next frame uses new word", 32'(sout_o), 32'(late[23 - n / 8]));
      @(negedge clk);
    end
  endtask

  task automatic t_rx(input logic [23:0] word);
    logic [23:0] prev;
    align();
    prev = rx_frame_o;
    for (int n = 0; n < 192; n++) begin
      if (n % 8 == 0) sin_i = word[23 - n / 8];
      if (n == 188) chk("R10 rx held before last sample", 32'(rx_frame_o), 32'(prev));
      if (n == 189) chk("R10 rx updated after slot C", 32'(rx_frame_o), 32'(word));
      @(negedge clk);
    end
    chk("R10 rx holds into next frame", 32'(rx_frame_o), 32'(word));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arming();
    t_clock_frame(1'b0);
    t_clock_frame(1'b1);
    t_relock();
    t_idle();
    t_pdown();
    t_tx(24'hA53CE1, 24'h5A0F96);
    t_tx(24'h800001, 24'hFF00FF);
    t_rx(24'hC3_7E_18);
    t_rx(24'h01_80_FF);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule